// File: doc/BRIEF.md
# GPIO Port with Pin Interrupts

This block is a 32-pin general-purpose I/O port controlled through a simple word-addressed register port. Each pin has its own bits for input enable, output enable, output value, pull-up enable, output inversion and a 3-bit drive strength. These bits drive the pad control outputs directly. Each pin's output can come from the software value register or from one of two alternate peripheral sources. The choice is made by an alternate-enable register and an alternate-select register.

Pad inputs pass through a two-flop synchronizer. The synchronized value, gated by input enable, is readable by software and is also returned to the peripherals. Every pin can raise four kinds of interrupt: rising edge, falling edge, high level and low level. Each kind has its own enable register and pending register. A single interrupt line combines all enabled pending bits.

Register word indices: 0 input value (read-only), 1 input enable, 2 output enable, 3 output value, 4 pull-up enable, 5/6/7 drive-strength bit planes 0/1/2, 8 output invert, 9 alternate enable, 10 alternate select, 11 rise enable, 12 rise pending, 13 fall enable, 14 fall pending, 15 high enable, 16 high pending, 17 low enable, 18 low pending. Reads are combinational from `bus_addr`. Writes take effect at the clock edge where `bus_sel` and `bus_wr` are both high.

Top module: `gpio_port`

## Requirements
- R1: After synchronous reset, every register is 0. pad_out, pad_oe, pad_ie, pad_pue, pad_ds and irq are all 0.
- R2: The writable configuration and enable registers read back the value last written. Any word index above 18 reads as 0.
- R3: pad_ie equals the input-enable register and pad_pue equals the pull-up register. pad_ds bits [3i+2:3i] carry pin i's drive code. Bit k of that code comes from bit plane k (index 5+k).
- R4: When a pin's alternate-enable bit is 0, its output data and output enable come from the output-value and output-enable registers. When the bit is 1, the alternate-select bit chooses alt1 (select 1) or alt0 (select 0) for both data and enable.
- R5: pad_out is the selected output data XOR the output-invert register, bit by bit.
- R6: The input value register and periph_in show pad_in AND input enable, two clock edges after pad_in changes.
- R7: A 0→1 change of a pin's synchronized input sets its rise pending bit, and a 1→0 change sets its fall pending bit. The bit is set at the third clock edge after pad_in changes and stays set until cleared.
- R8: Writing 1 to an edge pending bit clears it, and writing 0 leaves it unchanged. If a new edge on that bit arrives in the same cycle as the clear, the bit stays set.
- R9: The high pending bit equals the synchronized level AND input enable. The low pending bit equals the inverted synchronized level AND input enable. Writes to either register have no effect.
- R10: irq is 1 exactly when some pin has a pending bit of some kind whose matching enable bit is 1.
- R11: A pin with input enable 0 reads 0, raises no edge or level pending bits, and produces no edge when its input is re-enabled while the pad level is steady.
- R12: Writes to the input value register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, with bus_sel |
| bus_addr | input | 5 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pad_in | input | 32 | Raw pad input levels |
| pad_out | output | 32 | Pad output data |
| pad_oe | output | 32 | Pad output enable |
| pad_ie | output | 32 | Pad input buffer enable |
| pad_pue | output | 32 | Pad pull-up enable |
| pad_ds | output | 96 | Drive code, 3 bits per pin |
| alt0_out | input | 32 | Alternate source 0 data |
| alt0_oe | input | 32 | Alternate source 0 output enable |
| alt1_out | input | 32 | Alternate source 1 data |
| alt1_oe | input | 32 | Alternate source 1 output enable |
| periph_in | output | 32 | Synchronized, enabled inputs for peripherals |
| irq | output | 1 | Combined interrupt request |

## Verification
A software clear of an edge pending bit can coincide with a fresh edge detection on the same bit. The bench provokes this by changing pad_in two negative edges before it starts a write-1-to-clear of the rise pending register. The detection and the clear then both land on the third clock edge. The collision is judged by reading the register back: the bit must still be set, while the other bits cleared by the same write must read 0.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int GPIO_PINS = 32;
    localparam int GPIO_DSW  = 3;
    localparam int GPIO_AW   = 5;
    localparam int GPIO_DSB  = GPIO_PINS * GPIO_DSW;

    typedef logic [GPIO_PINS-1:0] pinvec_t;

    typedef enum logic [GPIO_AW-1:0] {
        REG_IN_VAL    = 5'd0,
        REG_IN_EN     = 5'd1,
        REG_OUT_EN    = 5'd2,
        REG_OUT_VAL   = 5'd3,
        REG_PULL_EN   = 5'd4,
        REG_DRIVE0    = 5'd5,
        REG_DRIVE1    = 5'd6,
        REG_DRIVE2    = 5'd7,
        REG_INVERT    = 5'd8,
        REG_ALT_EN    = 5'd9,
        REG_ALT_SEL   = 5'd10,
        REG_RISE_EN   = 5'd11,
        REG_RISE_PEND = 5'd12,
        REG_FALL_EN   = 5'd13,
        REG_FALL_PEND = 5'd14,
        REG_HIGH_EN   = 5'd15,
        REG_HIGH_PEND = 5'd16,
        REG_LOW_EN    = 5'd17,
        REG_LOW_PEND  = 5'd18
    } reg_idx_e;

    // Per-pin configuration state held in the register file.
    typedef struct packed {
        pinvec_t                    in_en;
        pinvec_t                    out_en;
        pinvec_t                    out_val;
        pinvec_t                    pull_en;
        pinvec_t                    invert;
        pinvec_t                    alt_en;
        pinvec_t                    alt_sel;
        logic [GPIO_DSW-1:0][GPIO_PINS-1:0] drive;
    } cfg_t;

    // One vector per interrupt kind.
    typedef struct packed {
        pinvec_t rise;
        pinvec_t fall;
        pinvec_t high;
        pinvec_t low;
    } irq_vec_t;

    function automatic logic any_armed(irq_vec_t pend, irq_vec_t en);
        return |((pend.rise & en.rise) | (pend.fall & en.fall) |
                 (pend.high & en.high) | (pend.low & en.low));
    endfunction

endpackage

// File: rtl/gpio_input_sync.sv
module gpio_input_sync
    import gpio_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  pinvec_t pad_in,
    input  pinvec_t in_en,
    output pinvec_t level,
    output pinvec_t rise_ev,
    output pinvec_t fall_ev
);
    localparam int LAST = STAGES - 1;

    pinvec_t chain [STAGES];
    pinvec_t prev;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '0;
                    else     chain[0] <= pad_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= chain[LAST];
    end

    assign level   = chain[LAST] & in_en;
    assign rise_ev =  chain[LAST] & ~prev & in_en;
    assign fall_ev = ~chain[LAST] &  prev & in_en;

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R6: first stage captures the pad one edge later
    assert_sync_stage_R6: assert property (@(posedge clk) disable iff (rst || !armed)
        chain[0] == $past(pad_in));

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [GPIO_AW-1:0] bus_addr,
    input  pinvec_t            bus_wdata,
    output pinvec_t            bus_rdata,
    input  pinvec_t            level,
    input  pinvec_t            rise_ev,
    input  pinvec_t            fall_ev,
    output cfg_t               cfg,
    output irq_vec_t           pend,
    output irq_vec_t           en
);
    logic    wr_go;
    pinvec_t rise_clr, fall_clr;
    pinvec_t rise_q, fall_q;

    assign wr_go    = bus_sel && bus_wr;
    assign rise_clr = (wr_go && bus_addr == REG_RISE_PEND) ? bus_wdata : '0;
    assign fall_clr = (wr_go && bus_addr == REG_FALL_PEND) ? bus_wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            en  <= '0;
        end else if (wr_go) begin
            case (bus_addr)
                REG_IN_EN:   cfg.in_en   <= bus_wdata;
                REG_OUT_EN:  cfg.out_en  <= bus_wdata;
                REG_OUT_VAL: cfg.out_val <= bus_wdata;
                REG_PULL_EN: cfg.pull_en <= bus_wdata;
                REG_INVERT:  cfg.invert  <= bus_wdata;
                REG_ALT_EN:  cfg.alt_en  <= bus_wdata;
                REG_ALT_SEL: cfg.alt_sel <= bus_wdata;
                REG_RISE_EN: en.rise     <= bus_wdata;
                REG_FALL_EN: en.fall     <= bus_wdata;
                REG_HIGH_EN: en.high     <= bus_wdata;
                REG_LOW_EN:  en.low      <= bus_wdata;
                default: begin
                    for (int k = 0; k < GPIO_DSW; k++) begin
                        if (bus_addr == GPIO_AW'(REG_DRIVE0) + GPIO_AW'(k))
                            cfg.drive[k] <= bus_wdata;
                    end
                end
            endcase
        end
    end

    // Edge pending: sticky, write-1-to-clear, new edge wins over clear.
    always_ff @(posedge clk) begin
        if (rst) begin
            rise_q <= '0;
            fall_q <= '0;
        end else begin
            rise_q <= (rise_q & ~rise_clr) | rise_ev;
            fall_q <= (fall_q & ~fall_clr) | fall_ev;
        end
    end

    assign pend.rise = rise_q;
    assign pend.fall = fall_q;
    assign pend.high = level;
    assign pend.low  = cfg.in_en & ~level;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_IN_VAL:    bus_rdata = level;
            REG_IN_EN:     bus_rdata = cfg.in_en;
            REG_OUT_EN:    bus_rdata = cfg.out_en;
            REG_OUT_VAL:   bus_rdata = cfg.out_val;
            REG_PULL_EN:   bus_rdata = cfg.pull_en;
            REG_INVERT:    bus_rdata = cfg.invert;
            REG_ALT_EN:    bus_rdata = cfg.alt_en;
            REG_ALT_SEL:   bus_rdata = cfg.alt_sel;
            REG_RISE_EN:   bus_rdata = en.rise;
            REG_RISE_PEND: bus_rdata = pend.rise;
            REG_FALL_EN:   bus_rdata = en.fall;
            REG_FALL_PEND: bus_rdata = pend.fall;
            REG_HIGH_EN:   bus_rdata = en.high;
            REG_HIGH_PEND: bus_rdata = pend.high;
            REG_LOW_EN:    bus_rdata = en.low;
            REG_LOW_PEND:  bus_rdata = pend.low;
            default: begin
                for (int k = 0; k < GPIO_DSW; k++) begin
                    if (bus_addr == GPIO_AW'(REG_DRIVE0) + GPIO_AW'(k))
                        bus_rdata = cfg.drive[k];
                end
            end
        endcase
    end

    // R7: a detected edge is recorded at the next edge
    assert_rise_set_R7: assert property (@(posedge clk) disable iff (rst)
        (rise_ev != '0) |=> ((rise_q & $past(rise_ev)) == $past(rise_ev)));
    assert_fall_set_R7: assert property (@(posedge clk) disable iff (rst)
        (fall_ev != '0) |=> ((fall_q & $past(fall_ev)) == $past(fall_ev)));
    // R7: without event or clear the pending bits hold
    assert_rise_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (rise_ev == '0 && !(wr_go && bus_addr == REG_RISE_PEND)) |=> $stable(rise_q));
    // R8: cleared bits read 0 unless a new edge arrived
    assert_rise_w1c_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_go && bus_addr == REG_RISE_PEND) |=>
        ((rise_q & $past(bus_wdata) & ~$past(rise_ev)) == '0));

endmodule

// File: rtl/gpio_out_mux.sv
module gpio_out_mux
    import gpio_pkg::*;
(
    input  cfg_t                 cfg,
    input  pinvec_t              alt0_out,
    input  pinvec_t              alt0_oe,
    input  pinvec_t              alt1_out,
    input  pinvec_t              alt1_oe,
    output pinvec_t              pad_out,
    output pinvec_t              pad_oe,
    output pinvec_t              pad_ie,
    output pinvec_t              pad_pue,
    output logic [GPIO_DSB-1:0]  pad_ds
);
    generate
        for (genvar i = 0; i < GPIO_PINS; i++) begin : g_pin
            logic d_sel, oe_sel;
            always_comb begin
                if (!cfg.alt_en[i]) begin
                    d_sel  = cfg.out_val[i];
                    oe_sel = cfg.out_en[i];
                end else if (cfg.alt_sel[i]) begin
                    d_sel  = alt1_out[i];
                    oe_sel = alt1_oe[i];
                end else begin
                    d_sel  = alt0_out[i];
                    oe_sel = alt0_oe[i];
                end
            end
            assign pad_out[i] = d_sel ^ cfg.invert[i];
            assign pad_oe[i]  = oe_sel;
            for (genvar k = 0; k < GPIO_DSW; k++) begin : g_ds
                assign pad_ds[i*GPIO_DSW + k] = cfg.drive[k][i];
            end
        end
    endgenerate

    assign pad_ie  = cfg.in_en;
    assign pad_pue = cfg.pull_en;

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [GPIO_AW-1:0]   bus_addr,
    input  logic [GPIO_PINS-1:0] bus_wdata,
    output logic [GPIO_PINS-1:0] bus_rdata,
    input  logic [GPIO_PINS-1:0] pad_in,
    output logic [GPIO_PINS-1:0] pad_out,
    output logic [GPIO_PINS-1:0] pad_oe,
    output logic [GPIO_PINS-1:0] pad_ie,
    output logic [GPIO_PINS-1:0] pad_pue,
    output logic [GPIO_DSB-1:0]  pad_ds,
    input  logic [GPIO_PINS-1:0] alt0_out,
    input  logic [GPIO_PINS-1:0] alt0_oe,
    input  logic [GPIO_PINS-1:0] alt1_out,
    input  logic [GPIO_PINS-1:0] alt1_oe,
    output logic [GPIO_PINS-1:0] periph_in,
    output logic                 irq
);
    cfg_t     cfg;
    irq_vec_t pend, en;
    pinvec_t  level, rise_ev, fall_ev;

    gpio_input_sync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pad_in  (pad_in),
        .in_en   (cfg.in_en),
        .level   (level),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    gpio_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .level     (level),
        .rise_ev   (rise_ev),
        .fall_ev   (fall_ev),
        .cfg       (cfg),
        .pend      (pend),
        .en        (en)
    );

    gpio_out_mux u_mux (
        .cfg      (cfg),
        .alt0_out (alt0_out),
        .alt0_oe  (alt0_oe),
        .alt1_out (alt1_out),
        .alt1_oe  (alt1_oe),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .pad_ie   (pad_ie),
        .pad_pue  (pad_pue),
        .pad_ds   (pad_ds)
    );

    assign periph_in = level;
    assign irq       = any_armed(pend, en);

    // R10: with every enable cleared the request line stays low
    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        ((en.rise | en.fall | en.high | en.low) == '0) |-> !irq);

endmodule

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
    import gpio_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] pad_in = '0, pad_out, pad_oe, pad_ie, pad_pue;
    logic [95:0] pad_ds;
    logic [31:0] alt0_out = '0, alt0_oe = '0, alt1_out = '0, alt1_oe = '0;
    logic [31:0] periph_in;
    logic        irq;

    int tests = 0, fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    gpio_port uut (.*);

    // out_val, invert, alt_en, alt_sel, expected pad_out (alt0=FFFF0000, alt1=00FF00FF)
    localparam logic [31:0] TBL [6][5] = '{
        '{32'h12345678, 32'h00000000, 32'h00000000, 32'h00000000, 32'h12345678},
        '{32'h12345678, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'hEDCBA987},
        '{32'h00000000, 32'h00000000, 32'hFFFFFFFF, 32'h00000000, 32'hFFFF0000},
        '{32'h00000000, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00FF00FF},
        '{32'hAAAAAAAA, 32'h00000000, 32'h0000FFFF, 32'h000000FF, 32'hAAAA00FF},
        '{32'hAAAAAAAA, 32'h0F0F0F0F, 32'h0000FFFF, 32'h000000FF, 32'hA5A50FF0}
    };

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called just after a negedge; consumes one rising edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        cyc(4);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        chk("R1 pad_out", pad_out, 0);
        chk("R1 pad_oe", pad_oe, 0);
        chk("R1 pad_ds", pad_ds, 0);
        chk("R1 pad_ie", pad_ie, 0);
        chk("R1 irq", irq, 0);
        rd(REG_ALT_EN, v); chk("R1 alt_en", v, 0);

        // R2 readback, R3 pad controls
        wr(REG_PULL_EN, 32'hDEADBEEF);
        rd(REG_PULL_EN, v); chk("R2 pull readback", v, 32'hDEADBEEF);
        chk("R3 pad_pue", pad_pue, 32'hDEADBEEF);
        rd(5'd25, v); chk("R2 unmapped", v, 0);
        wr(REG_DRIVE0, 32'h1); wr(REG_DRIVE1, 32'h2); wr(REG_DRIVE2, 32'h4);
        chk("R3 pad_ds", pad_ds, 96'h111);
        rd(REG_DRIVE1, v); chk("R2 drive1 readback", v, 32'h2);

        // R4/R5 table
        alt0_out = 32'hFFFF0000; alt1_out = 32'h00FF00FF;
        for (int e = 0; e < 6; e++) begin
            wr(REG_OUT_VAL, TBL[e][0]);
            wr(REG_INVERT,  TBL[e][1]);
            wr(REG_ALT_EN,  TBL[e][2]);
            wr(REG_ALT_SEL, TBL[e][3]);
            chk($sformatf("R4 R5 table entry %0d", e), pad_out, TBL[e][4]);
        end
        // R4 output enable routing
        wr(REG_OUT_EN, 32'h0000FFFF); wr(REG_ALT_EN, 32'hFF00FF00);
        wr(REG_ALT_SEL, 32'hF000F000);
        alt0_oe = 32'h0; alt1_oe = 32'hFFFFFFFF;
        #1 chk("R4 pad_oe", pad_oe, 32'hF000F0FF);

        // R6 input sync
        wr(REG_IN_EN, 32'hFFFFFFFF);
        chk("R3 pad_ie", pad_ie, 32'hFFFFFFFF);
        pad_in = 32'h0000A5A5;
        cyc(1);
        rd(REG_IN_VAL, v); chk("R6 after one edge", v, 0);
        cyc(1);
        rd(REG_IN_VAL, v); chk("R6 after two edges", v, 32'h0000A5A5);
        chk("R6 periph_in", periph_in, 32'h0000A5A5);
        rd(REG_RISE_PEND, v); chk("R7 rise not yet", v, 0);
        rd(REG_HIGH_PEND, v); chk("R9 high level", v, 32'h0000A5A5);
        rd(REG_LOW_PEND, v); chk("R9 low level", v, 32'hFFFF5A5A);
        cyc(1);
        rd(REG_RISE_PEND, v); chk("R7 rise set", v, 32'h0000A5A5);
        chk("R10 irq masked", irq, 0);
        wr(REG_RISE_EN, 32'h1);
        chk("R10 irq raised", irq, 1);

        // R8 clear semantics
        wr(REG_RISE_PEND, 32'h4);
        rd(REG_RISE_PEND, v); chk("R8 w1c one bit", v, 32'h0000A5A1);
        wr(REG_RISE_PEND, 32'h0);
        rd(REG_RISE_PEND, v); chk("R8 write zero", v, 32'h0000A5A1);
        wr(REG_RISE_PEND, 32'hFFFFFFFF);
        rd(REG_RISE_PEND, v); chk("R8 clear all", v, 0);
        chk("R10 irq dropped", irq, 0);
        wr(REG_HIGH_PEND, 32'h0);
        rd(REG_HIGH_PEND, v); chk("R9 write ignored", v, 32'h0000A5A5);
        wr(REG_IN_VAL, 32'h12345678);
        rd(REG_IN_VAL, v); chk("R12 write ignored", v, 32'h0000A5A5);
        wr(REG_LOW_EN, 32'h80000000);
        chk("R10 low level irq", irq, 1);
        wr(REG_LOW_EN, 32'h0);

        // R8 collision: edge detected on the same edge as the clear
        pad_in = 32'h0000A5A7;
        cyc(2);
        wr(REG_RISE_PEND, 32'hFFFFFFFF);
        rd(REG_RISE_PEND, v); chk("R8 edge beats clear", v, 32'h2);
        wr(REG_RISE_PEND, 32'hFFFFFFFF);

        // R7 fall
        pad_in = 32'h0;
        cyc(3);
        rd(REG_FALL_PEND, v); chk("R7 fall set", v, 32'h0000A5A7);

        // R11 disabled inputs
        wr(REG_IN_EN, 32'h0);
        wr(REG_FALL_PEND, 32'hFFFFFFFF);
        pad_in = 32'hFFFFFFFF;
        cyc(4);
        rd(REG_IN_VAL, v);    chk("R11 reads zero", v, 0);
        rd(REG_RISE_PEND, v); chk("R11 no rise", v, 0);
        rd(REG_HIGH_PEND, v); chk("R11 no high", v, 0);
        rd(REG_LOW_PEND, v);  chk("R11 no low", v, 0);
        wr(REG_IN_EN, 32'hFFFFFFFF);
        cyc(3);
        rd(REG_RISE_PEND, v); chk("R11 no edge on enable", v, 0);
        rd(REG_IN_VAL, v);    chk("R11 re-enabled level", v, 32'hFFFFFFFF);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule